// File: doc/BRIEF.md
# Configurable Pixel Format Packer

The packer takes one pixel per cycle, with 8-bit alpha, red, green and blue channels, and turns it into a 16-, 24- or 32-bit output word. A 4-bit format code selects the bit width, the channel order and the precision of each channel. The same pixel is also qualified by an alpha mode, a per-lane write mask and an invert flag. Each output word comes with a byte count and per-lane strobes, so a downstream writer can store only the lanes that are meant to change.

Both sides use a valid/ready handshake. There are two register stages. With no back-pressure, a pixel accepted at one clock edge appears on the output after the next edge. Pixels that carry an undefined format code are still accepted, but they make no output word. Instead they set an error flag, which stays set until reset.

Top module: `pix_packer`

## Requirements
- R1: After the asynchronous reset `word_valid_o` is 0, `fmt_err_o` is 0 and `pix_ready_o` is 1.
- R2: Codes 12..15 give a 4-byte word. The bytes from lane 3 down to lane 0 are: 12 A,B,G,R; 13 A,R,G,B; 14 B,G,R,A; 15 R,G,B,A.
- R3: Codes 0..3 give a 2-byte word of four nibbles in the same orders as codes 12..15, in the same sequence (code 0 = A,B,G,R from bit 15 down). Each nibble is the upper 4 bits of its channel.
- R4: Codes 6 and 7 give a 2-byte word. Bits 15:11 hold the upper 5 bits of B (code 6) or R (code 7). Bits 10:5 hold the upper 6 bits of G. Bits 4:0 hold the upper 5 bits of the remaining channel.
- R5: Codes 8 and 9 give a 3-byte word. Lanes 2,1,0 hold B,G,R (code 8) or R,G,B (code 9). Lane 3 is zero.
- R6: In the formats with alpha, when `alpha_en_i`=1 the alpha field carries the input alpha. If `alpha_inv_i`=1 it carries the bitwise inverse instead.
- R7: In the formats with alpha, when `alpha_en_i`=0 the alpha field is filled with all ones if `alpha_inv_i`=1, and with zeros otherwise.
- R8: `word_bytes_o` is 2, 3 or 4 as set by the format. Unused upper lanes of `word_data_o` are zero. Bit i of `word_strb_o` is the AND of "lane i is used" and bit i of `lane_en_i`.
- R9: Codes 4, 5, 10 and 11 are accepted but make no output word. `fmt_err_o` rises in the cycle after such a pixel is accepted and stays high until reset.
- R10: Output words keep the input order. While `word_valid_o`=1 and `word_ready_i`=0, the word, count and strobes hold steady. With no stall, a pixel accepted at one edge is presented after the following edge.
- R11: `pix_ready_o` is 0 only when both stages are full and `word_ready_i` is 0. No accepted pixel is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Packer can take a pixel |
| pix_argb_i | input | 32 | Pixel: alpha [31:24], red [23:16], green [15:8], blue [7:0] |
| fmt_i | input | 4 | Format code, sampled with the pixel |
| alpha_en_i | input | 1 | Store input alpha (1) or fill it (0) |
| alpha_inv_i | input | 1 | Invert stored alpha, or choose an all-ones fill |
| lane_en_i | input | 4 | Per-lane write mask, 4'hF for normal use |
| word_valid_o | output | 1 | Packed word valid |
| word_ready_i | input | 1 | Downstream takes the word |
| word_data_o | output | 32 | Packed word, lane 0 in bits 7:0 |
| word_bytes_o | output | 3 | Number of meaningful bytes (2, 3 or 4) |
| word_strb_o | output | 4 | Per-lane store strobes |
| fmt_err_o | output | 1 | Sticky undefined-format flag |

## Verification
The bench aims at the places where channel order flips: red/blue swaps and alpha-first versus alpha-last layouts in every class. A design that decodes the order bits the wrong way would put bytes in mirrored positions. Truncation to 4, 5 and 6 bits is checked with channel values whose low bits differ from their high bits, so a design that kept the low bits would give visibly wrong fields. The bench also checks all four alpha combinations, since swapping the fill values or inverting a fill would show up there. It mixes undefined codes into the random traffic and checks that no word leaks out and that the flag never drops. Back-pressure runs are there to catch a pipeline that drops or repeats a word when its stages fill.

// File: rtl/pix_packer_pkg.sv
package pix_packer_pkg;
  localparam int CH_W   = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANES * CH_W;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int FMT_W  = 4;

  typedef enum logic [1:0] {
    CLS_4444 = 2'b00,
    CLS_565  = 2'b01,
    CLS_888  = 2'b10,
    CLS_8888 = 2'b11
  } fmt_cls_e;

  typedef struct packed {
    logic [FMT_W-1:0] code;
    logic [CH_W-1:0]  a;
    logic [CH_W-1:0]  r;
    logic [CH_W-1:0]  g;
    logic [CH_W-1:0]  b;
    logic [LANES-1:0] lane_en;
  } px_t;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [CNT_W-1:0]  nbytes;
    logic [LANES-1:0]  strb;
  } word_t;

  // 565 needs code[1]=1, 888 needs code[1]=0
  function automatic logic fmt_ok(input logic [FMT_W-1:0] code);
    unique case (fmt_cls_e'(code[3:2]))
      CLS_565: fmt_ok = code[1];
      CLS_888: fmt_ok = ~code[1];
      default: fmt_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pp_alpha.sv
module pp_alpha
  import pix_packer_pkg::*;
(
  input  logic [CH_W-1:0] a_i,
  input  logic            en_i,
  input  logic            inv_i,
  output logic [CH_W-1:0] a_o
);
  always_comb begin
    if (en_i) a_o = inv_i ? ~a_i : a_i;
    else      a_o = inv_i ? '1 : '0;
  end
endmodule

// File: rtl/pp_stage.sv
module pp_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  output logic         rdy_o,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  input  logic         rdy_i,
  output logic [W-1:0] dat_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign rdy_o = ~vld_q | rdy_i;
  assign vld_o = vld_q;
  assign dat_o = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else if (rdy_o) vld_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (rdy_o && vld_i) dat_q <= dat_i;
  end
endmodule

// File: rtl/pp_pack.sv
module pp_pack
  import pix_packer_pkg::*;
(
  input  px_t   px_i,
  output word_t word_o
);
  fmt_cls_e        cls;
  logic [CH_W-1:0] hi_rb, lo_rb;
  logic [CH_W-1:0] c3, c2, c1, c0;
  logic [LANES-1:0] used;

  assign cls   = fmt_cls_e'(px_i.code[3:2]);
  assign hi_rb = px_i.code[0] ? px_i.r : px_i.b;
  assign lo_rb = px_i.code[0] ? px_i.b : px_i.r;

  // code[1]: alpha in the lowest field instead of the highest
  always_comb begin
    if (px_i.code[1]) begin
      c3 = hi_rb;  c2 = px_i.g; c1 = lo_rb;  c0 = px_i.a;
    end else begin
      c3 = px_i.a; c2 = hi_rb;  c1 = px_i.g; c0 = lo_rb;
    end
  end

  always_comb begin
    word_o.data = '0;
    unique case (cls)
      CLS_4444: begin
        word_o.data[15:0] = {c3[CH_W-1 -: 4], c2[CH_W-1 -: 4],
                             c1[CH_W-1 -: 4], c0[CH_W-1 -: 4]};
        word_o.nbytes = CNT_W'(2);
        used = 4'b0011;
      end
      CLS_565: begin
        word_o.data[15:0] = {hi_rb[CH_W-1 -: 5], px_i.g[CH_W-1 -: 6],
                             lo_rb[CH_W-1 -: 5]};
        word_o.nbytes = CNT_W'(2);
        used = 4'b0011;
      end
      CLS_888: begin
        word_o.data[3*CH_W-1:0] = {hi_rb, px_i.g, lo_rb};
        word_o.nbytes = CNT_W'(3);
        used = 4'b0111;
      end
      default: begin
        word_o.data = {c3, c2, c1, c0};
        word_o.nbytes = CNT_W'(4);
        used = 4'b1111;
      end
    endcase
    word_o.strb = used & px_i.lane_en;
  end
endmodule

// File: rtl/pix_packer.sv
module pix_packer
  import pix_packer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  input  logic [WORD_W-1:0] pix_argb_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic              alpha_en_i,
  input  logic              alpha_inv_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic [CNT_W-1:0]  word_bytes_o,
  output logic [LANES-1:0]  word_strb_o,
  output logic              fmt_err_o
);
  localparam int PX_W = $bits(px_t);
  localparam int WD_W = $bits(word_t);

  logic            code_ok;
  logic [CH_W-1:0] a_mod;
  px_t             px_in, px_s1;
  word_t           wd_s1, wd_s2;
  logic            vld_s1, rdy_s1;
  logic            err_q;

  assign code_ok = fmt_ok(fmt_i);

  pp_alpha u_alpha (
    .a_i   (pix_argb_i[4*CH_W-1 -: CH_W]),
    .en_i  (alpha_en_i),
    .inv_i (alpha_inv_i),
    .a_o   (a_mod)
  );

  always_comb begin
    px_in.code    = fmt_i;
    px_in.a       = a_mod;
    px_in.r       = pix_argb_i[3*CH_W-1 -: CH_W];
    px_in.g       = pix_argb_i[2*CH_W-1 -: CH_W];
    px_in.b       = pix_argb_i[CH_W-1:0];
    px_in.lane_en = lane_en_i;
  end

  // undefined codes are consumed here and never enter the pipe
  pp_stage #(.W(PX_W)) u_s1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (pix_valid_i & code_ok),
    .rdy_o (pix_ready_o),
    .dat_i (px_in),
    .vld_o (vld_s1),
    .rdy_i (rdy_s1),
    .dat_o (px_s1)
  );

  pp_pack u_pack (
    .px_i  (px_s1),
    .word_o(wd_s1)
  );

  pp_stage #(.W(WD_W)) u_s2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_s1),
    .rdy_o (rdy_s1),
    .dat_i (wd_s1),
    .vld_o (word_valid_o),
    .rdy_i (word_ready_i),
    .dat_o (wd_s2)
  );

  assign word_data_o  = wd_s2.data;
  assign word_bytes_o = wd_s2.nbytes;
  assign word_strb_o  = wd_s2.strb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (pix_valid_i && pix_ready_o && !code_ok) err_q <= 1'b1;
  end
  assign fmt_err_o = err_q;
endmodule

// File: rtl/pix_packer_chk.sv
module pix_packer_chk
  import pix_packer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_ready_o,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [WORD_W-1:0] word_data_o,
  input logic [CNT_W-1:0]  word_bytes_o,
  input logic [LANES-1:0]  word_strb_o,
  input logic              fmt_err_o
);
  a_r10_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o)
      && $stable(word_bytes_o) && $stable(word_strb_o));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> fmt_err_o);

  a_r8_bytes_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_bytes_o == CNT_W'(2) || word_bytes_o == CNT_W'(3)
                      || word_bytes_o == CNT_W'(4)));

  a_r8_strb_in_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_strb_o >> word_bytes_o) == '0);

  a_r11_stall_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_ready_o |-> word_valid_o && !word_ready_i);
endmodule

bind pix_packer pix_packer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_ready_o (pix_ready_o),
  .word_valid_o(word_valid_o),
  .word_ready_i(word_ready_i),
  .word_data_o (word_data_o),
  .word_bytes_o(word_bytes_o),
  .word_strb_o (word_strb_o),
  .fmt_err_o   (fmt_err_o)
);

// File: tb/pix_packer_test.sv
module pix_packer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic        pix_ready_o;
  logic [31:0] pix_argb_i = '0;
  logic [3:0]  fmt_i = '0;
  logic        alpha_en_i = 1'b0;
  logic        alpha_inv_i = 1'b0;
  logic [3:0]  lane_en_i = 4'hF;
  logic        word_valid_o;
  logic        word_ready_i = 1'b1;
  logic [31:0] word_data_o;
  logic [2:0]  word_bytes_o;
  logic [3:0]  word_strb_o;
  logic        fmt_err_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [38:0] expq[$];
  string       tagq[$];
  bit          err_exp = 0;
  bit          prev_stall = 0;
  logic [38:0] prev_word;

  always #4 clk_i = ~clk_i; // 125 MHz

  pix_packer uut (.*);

  function automatic logic [38:0] ref_word(input logic [31:0] p, input int f,
                                            input bit aen, input bit ainv,
                                            input logic [3:0] len);
    logic [7:0] a, r, g, b;
    logic [31:0] d;
    int n;
    logic [3:0] m;
    a = aen ? (ainv ? ~p[31:24] : p[31:24]) : (ainv ? 8'hFF : 8'h00);
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    d = 0; n = 4;
    case (f)
      0:  begin d[15:0] = {a[7:4], b[7:4], g[7:4], r[7:4]}; n = 2; end
      1:  begin d[15:0] = {a[7:4], r[7:4], g[7:4], b[7:4]}; n = 2; end
      2:  begin d[15:0] = {b[7:4], g[7:4], r[7:4], a[7:4]}; n = 2; end
      3:  begin d[15:0] = {r[7:4], g[7:4], b[7:4], a[7:4]}; n = 2; end
      6:  begin d[15:0] = {b[7:3], g[7:2], r[7:3]}; n = 2; end
      7:  begin d[15:0] = {r[7:3], g[7:2], b[7:3]}; n = 2; end
      8:  begin d[23:0] = {b, g, r}; n = 3; end
      9:  begin d[23:0] = {r, g, b}; n = 3; end
      12: d = {a, b, g, r};
      13: d = {a, r, g, b};
      14: d = {b, g, r, a};
      default: d = {r, g, b, a};
    endcase
    m = (n == 2) ? 4'b0011 : (n == 3) ? 4'b0111 : 4'b1111;
    return {d, 3'(n), m & len};
  endfunction

  function automatic string tag_of(input int f, input bit aen);
    string s;
    if (f <= 3)      s = "R3";
    else if (f <= 7) s = "R4";
    else if (f <= 9) s = "R5";
    else             s = "R2";
    if (f <= 3 || f >= 12) s = {s, aen ? "/R6" : "/R7"};
    return {s, "/R8/R10"};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [38:0] act,
                     input logic [38:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs are set at a negedge; this observes them and moves to the next negedge
  task automatic cycle();
    logic [38:0] w, e;
    string t;
    #1;
    if (rst_ni) begin
      w = {word_data_o, word_bytes_o, word_strb_o};
      chk(fmt_err_o == err_exp, "R9 err flag", 39'(fmt_err_o), 39'(err_exp));
      if (prev_stall)
        chk(word_valid_o && w == prev_word, "R10 hold", w, prev_word);
      if (word_valid_o && word_ready_i) begin
        if (expq.size() == 0) chk(0, "R9 unexpected word", w, 0);
        else begin
          e = expq.pop_front(); t = tagq.pop_front();
          chk(w == e, t, w, e);
        end
      end
      prev_stall = word_valid_o && !word_ready_i;
      prev_word  = w;
      if (pix_valid_i && pix_ready_o) begin
        if (fmt_i inside {4, 5, 10, 11}) err_exp = 1;
        else begin
          expq.push_back(ref_word(pix_argb_i, fmt_i, alpha_en_i, alpha_inv_i, lane_en_i));
          tagq.push_back(tag_of(fmt_i, alpha_en_i));
        end
      end
    end
    @(negedge clk_i);
  endtask

  task automatic send(input logic [31:0] p, input int f, input bit aen,
                      input bit ainv, input logic [3:0] len);
    pix_valid_i = 1; pix_argb_i = p; fmt_i = 4'(f);
    alpha_en_i = aen; alpha_inv_i = ainv; lane_en_i = len;
    cycle();
    while (!pix_ready_o) cycle(); // R11 hold until taken
    pix_valid_i = 0;
  endtask

  task automatic drain();
    word_ready_i = 1; pix_valid_i = 0;
    for (int i = 0; i < 20; i++) cycle();
    chk(expq.size() == 0, "R11 no loss", 39'(expq.size()), 0);
  endtask

  task automatic do_reset();
    rst_ni = 0; pix_valid_i = 0;
    repeat (3) @(negedge clk_i);
    expq.delete(); tagq.delete(); err_exp = 0; prev_stall = 0;
    rst_ni = 1;
    #1;
    chk(!word_valid_o, "R1 valid low", 39'(word_valid_o), 0);
    chk(!fmt_err_o, "R1 err low", 39'(fmt_err_o), 0);
    chk(pix_ready_o, "R1 ready high", 39'(pix_ready_o), 1);
    @(negedge clk_i);
  endtask

  initial begin
    int f;
    int fmts[12] = '{0, 1, 2, 3, 6, 7, 8, 9, 12, 13, 14, 15};
    do_reset();

    // R10 latency: accept at edge n, visible after edge n+1
    send(32'h9CE35A17, 13, 1, 0, 4'hF);
    chk(!word_valid_o, "R10 latency early", 39'(word_valid_o), 0);
    cycle();
    chk(word_valid_o, "R10 latency", 39'(word_valid_o), 1);
    drain();

    // R2..R7 every code, all alpha modes, back-to-back
    foreach (fmts[i])
      for (int m = 0; m < 4; m++) begin
        send(32'h9CE35A17, fmts[i], m[1], m[0], 4'hF);
        send(32'h3B81C6F4, fmts[i], m[1], m[0], 4'hF);
      end
    drain();

    // R8 lane masks
    for (int k = 0; k < 16; k++) send(32'h11223344, (k % 3 == 0) ? 6 : (k % 3 == 1) ? 9 : 14, 1, 0, 4'(k));
    drain();

    // R11 back-pressure: two stages fill, then ready drops
    word_ready_i = 0;
    pix_valid_i = 1; pix_argb_i = 32'hA1B2C3D4; fmt_i = 15; alpha_en_i = 1; alpha_inv_i = 0; lane_en_i = 4'hF;
    cycle(); cycle();
    chk(!pix_ready_o, "R11 stall", 39'(pix_ready_o), 0);
    repeat (3) cycle();
    pix_valid_i = 0;
    drain();

    // R9 undefined code: no word, sticky flag
    send(32'hDEADBEEF, 4, 1, 1, 4'hF);
    cycle();
    chk(fmt_err_o, "R9 flag set", 39'(fmt_err_o), 1);
    send(32'h01020304, 12, 0, 1, 4'hF);
    send(32'h05060708, 10, 0, 0, 4'hF);
    drain();

    // mixed random traffic with stalls, including undefined codes
    for (int i = 0; i < 600; i++) begin
      f = $urandom_range(0, 15);
      pix_valid_i = ($urandom_range(0, 4) != 0);
      pix_argb_i = $urandom; fmt_i = 4'(f);
      alpha_en_i = 1'($urandom); alpha_inv_i = 1'($urandom);
      lane_en_i = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      word_ready_i = (i % 5 != 3) && (i % 37 < 30);
      cycle();
    end
    drain();

    // R1 reset clears sticky flag
    do_reset();
    send(32'h0F0F0F0F, 7, 0, 0, 4'hF);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule